// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block connects a 32-bit bus slave port with classic single-cycle handshake semantics (cycle, strobe, write flag, byte address, byte selects, acknowledge) to external asynchronous static RAM. The data path to the memory is 32, 16 or 8 bits wide, depending on how the RAM is built: one 32-bit part, two 16-bit parts side by side, one 16-bit part, two 8-bit parts side by side, or one 8-bit part. The bridge splits each 32-bit host transfer into as many memory beats as that width needs. It generates the memory address for every beat. It drives the strobes and the byte lanes. It gathers read data back into one host word.

Every memory beat passes through stages, and each stage lasts a parameterised number of clock cycles, never fewer than one. A read beat has an address setup stage followed by a data sample stage. A write beat has an address setup stage, a write-enable pulse and an address hold stage. The memory data pins are split into an input, an output and an output enable, so the pad ring builds the three-state driver.

Top module: `sram_bridge`

## Requirements
- R1: The memory data width and the beats per host word follow `LAYOUT`. LAY_ONE32 and LAY_TWO16 use 32 bits in 1 beat. LAY_ONE16 and LAY_TWO8 use 16 bits in 2 beats. LAY_ONE8 uses 8 bits in 4 beats.
- R2: `mem_adr_o` is `ADDR_W - s` bits wide, where s is 2, 1 or 0 for 32-, 16- or 8-bit memory width. For beat k the address is `{wb_adr_i[ADDR_W-1:2], k}`, and k is left out when there is one beat. Host address bits [1:0] are ignored. Beat k carries host bytes k*B to k*B+B-1, where B is the memory width in bytes, so the data is little-endian.
- R3: A read beat holds the address with chip and output enable low for `SETUP_CYC` cycles, then for `READ_CYC` more. Data is sampled at the end of that second stage. One read beat therefore lasts at least 2 cycles.
- R4: A write beat drives address and data for `SETUP_CYC` cycles. Write enable is then low for exactly `PULSE_CYC` cycles. Address and data are then held for `HOLD_CYC` cycles. One write beat lasts at least 3 cycles.
- R5: `wb_ack_o` is high for exactly one cycle. Counting the accepting edge as edge 1, the acknowledge appears after edge N·beat_length+1, where N is the number of beats performed. On a read, `wb_dat_o` holds the fully assembled word during that acknowledge cycle.
- R6: `mem_ce_n`, `mem_oe_n` and `mem_we_n` are active low. Output enable is low only during read beats. `mem_dq_oe` is high only during write beats, and never while output enable is low.
- R7: During a write beat, `mem_be_n[i]` is low exactly when host byte select `wb_sel_i[k*B+i]` is set for that beat k. During a read beat, all lane enables are low.
- R8: A write beat whose host byte selects are all clear is skipped, with no write-enable pulse. A write with `wb_sel_i == 0` produces no pulse and is acknowledged after the accepting edge.
- R9: Address and write data do not change while write enable is low, nor in the first cycle after it rises. Write enable never goes low in a cycle where the address changed.
- R10: After reset, chip, output and write enable are high, `mem_be_n` is all ones, and `mem_dq_oe` and `wb_ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W | Byte address (bits [1:0] ignored) |
| wb_sel_i | input | 4 | Byte selects for writes |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | One-cycle transfer acknowledge |
| mem_adr_o | output | MEM_AW | Memory word address |
| mem_dq_i | input | MEM_DW | Data read from memory pins |
| mem_dq_o | output | MEM_DW | Data driven to memory pins |
| mem_dq_oe | output | 1 | Enable for the data pin drivers |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | MEM_DW/8 | Byte lane enables, active low |

## Verification
The bench drives an 8-bit, four-beat bridge with stretched stages, and a 32-bit, single-beat bridge with one-cycle stages. It checks both against memory models and a reference byte image of its own. It writes with partial byte selects, with selects that leave whole beats empty, and with all selects clear. A design that skipped no beats, or skipped the wrong ones, would show a wrong pulse count, a wrong acknowledge latency or corrupted bytes. Reading back and inspecting the model bytes catches a beat order or address offset that is swapped. Monitors flag any address movement under write enable, any overlap between output enable and driven data, and a pulse length other than the configured one.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    LAY_ONE32 = 3'd0,
    LAY_ONE16 = 3'd1,
    LAY_ONE8  = 3'd2,
    LAY_TWO16 = 3'd3,
    LAY_TWO8  = 3'd4
  } layout_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_ACT,
    SQ_HOLD,
    SQ_ACK
  } seq_state_e;

  // bytes moved per memory beat
  function automatic int lane_bytes(layout_e l);
    case (l)
      LAY_ONE32, LAY_TWO16: return 4;
      LAY_ONE16, LAY_TWO8:  return 2;
      default:              return 1;
    endcase
  endfunction

  // host address bits dropped for the memory address
  function automatic int lane_shift(layout_e l);
    case (l)
      LAY_ONE32, LAY_TWO16: return 2;
      LAY_ONE16, LAY_TWO8:  return 1;
      default:              return 0;
    endcase
  endfunction

  function automatic int beat_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_lane_steer.sv
// Splits the host word and byte selects into per-beat slices.
module sram_lane_steer
  import sram_bridge_pkg::*;
#(
  parameter int BEATS = 1,
  localparam int DW     = 32 / BEATS,
  localparam int LANES  = DW / 8,
  localparam int BEAT_W = beat_bits(BEATS)
) (
  input  logic              we,
  input  logic [3:0]        sel,
  input  logic [31:0]       wdata,
  input  logic [BEAT_W-1:0] beat,
  output logic [DW-1:0]     beat_data,
  output logic [LANES-1:0]  beat_lanes,
  output logic [BEATS-1:0]  used
);

  logic [DW-1:0]    dslice [BEATS];
  logic [LANES-1:0] sslice [BEATS];

  for (genvar b = 0; b < BEATS; b++) begin : g_slice
    assign dslice[b] = wdata[b*DW +: DW];
    assign sslice[b] = sel[b*LANES +: LANES];
    // reads touch every beat; writes only beats with a selected byte
    assign used[b]   = !we || (|sslice[b]);
  end

  if (BEATS == 1) begin : g_single
    assign beat_data  = dslice[0];
    assign beat_lanes = sslice[0];
  end else begin : g_multi
    assign beat_data  = dslice[beat];
    assign beat_lanes = sslice[beat];
  end

endmodule

// File: rtl/sram_read_gather.sv
// Collects read beats into the host word, little-endian.
module sram_read_gather
  import sram_bridge_pkg::*;
#(
  parameter int BEATS = 1,
  localparam int DW     = 32 / BEATS,
  localparam int BEAT_W = beat_bits(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [BEAT_W-1:0] beat,
  input  logic [DW-1:0]     din,
  output logic [31:0]       word_o
);

  logic [DW-1:0] part [BEATS];

  for (genvar b = 0; b < BEATS; b++) begin : g_part
    always_ff @(posedge clk) begin
      if (rst)
        part[b] <= '0;
      else if (cap && beat == BEAT_W'(b))
        part[b] <= din;
    end
    assign word_o[b*DW +: DW] = part[b];
  end

endmodule

// File: rtl/sram_seq.sv
// Beat and stage sequencer; strobes are registered from the next state.
module sram_seq
  import sram_bridge_pkg::*;
#(
  parameter int BEATS     = 1,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 1,
  localparam int BEAT_W = beat_bits(BEATS),
  localparam int CNT_W  = $clog2(max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, READ_CYC) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [BEATS-1:0]  used,
  output logic              busy,
  output logic              accept,
  output logic              load,
  output logic              cap,
  output logic [BEAT_W-1:0] beat_cur,
  output logic [BEAT_W-1:0] beat_nxt,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dq_oe,
  output logic              ack
);

  seq_state_e        state, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BEAT_W-1:0] beat, beat_n;
  logic              f0_ok, fn_ok;
  logic [BEAT_W-1:0] f0_idx, fn_idx;

  always_comb begin
    f0_ok  = 1'b0;
    fn_ok  = 1'b0;
    f0_idx = '0;
    fn_idx = '0;
    // descending scan so the lowest qualifying beat wins
    for (int b = BEATS - 1; b >= 0; b--) begin
      if (used[b]) begin
        f0_ok  = 1'b1;
        f0_idx = BEAT_W'(b);
      end
      if (used[b] && b > int'(beat)) begin
        fn_ok  = 1'b1;
        fn_idx = BEAT_W'(b);
      end
    end
  end

  always_comb begin
    st_n   = state;
    cnt_n  = cnt;
    beat_n = beat;
    accept = 1'b0;
    load   = 1'b0;
    cap    = 1'b0;
    case (state)
      SQ_IDLE: begin
        if (req) begin
          accept = 1'b1;
          if (f0_ok) begin
            st_n   = SQ_SETUP;
            beat_n = f0_idx;
            cnt_n  = CNT_W'(SETUP_CYC - 1);
            load   = 1'b1;
          end else begin
            st_n = SQ_ACK;
          end
        end
      end
      SQ_SETUP: begin
        if (cnt == '0) begin
          st_n  = SQ_ACT;
          cnt_n = we ? CNT_W'(PULSE_CYC - 1) : CNT_W'(READ_CYC - 1);
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      SQ_ACT: begin
        if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end else if (we) begin
          st_n  = SQ_HOLD;
          cnt_n = CNT_W'(HOLD_CYC - 1);
        end else begin
          cap = 1'b1;
          if (fn_ok) begin
            st_n   = SQ_SETUP;
            beat_n = fn_idx;
            cnt_n  = CNT_W'(SETUP_CYC - 1);
            load   = 1'b1;
          end else begin
            st_n = SQ_ACK;
          end
        end
      end
      SQ_HOLD: begin
        if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end else if (fn_ok) begin
          st_n   = SQ_SETUP;
          beat_n = fn_idx;
          cnt_n  = CNT_W'(SETUP_CYC - 1);
          load   = 1'b1;
        end else begin
          st_n = SQ_ACK;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      beat  <= '0;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      ack   <= 1'b0;
    end else begin
      state <= st_n;
      cnt   <= cnt_n;
      beat  <= beat_n;
      ce_n  <= !(st_n inside {SQ_SETUP, SQ_ACT, SQ_HOLD});
      oe_n  <= !(!we && (st_n inside {SQ_SETUP, SQ_ACT}));
      we_n  <= !(we && st_n == SQ_ACT);
      dq_oe <= we && (st_n inside {SQ_SETUP, SQ_ACT, SQ_HOLD});
      ack   <= (st_n == SQ_ACK);
    end
  end

  assign busy     = (state != SQ_IDLE);
  assign beat_cur = beat;
  assign beat_nxt = beat_n;

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int      ADDR_W    = 16,
  parameter layout_e LAYOUT    = LAY_ONE32,
  parameter int      SETUP_CYC = 1,
  parameter int      PULSE_CYC = 1,
  parameter int      HOLD_CYC  = 1,
  parameter int      READ_CYC  = 1,
  localparam int LANES  = lane_bytes(LAYOUT),
  localparam int MEM_DW = 8 * LANES,
  localparam int MEM_AW = ADDR_W - lane_shift(LAYOUT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [3:0]        wb_sel_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  output logic [MEM_AW-1:0] mem_adr_o,
  input  logic [MEM_DW-1:0] mem_dq_i,
  output logic [MEM_DW-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n
);

  localparam int BEATS  = 4 / LANES;
  localparam int BEAT_W = beat_bits(BEATS);
  localparam int WORD_W = ADDR_W - 2;

  logic              busy, accept, load, cap;
  logic [BEAT_W-1:0] beat_cur, beat_nxt;
  logic [BEATS-1:0]  used;
  logic [MEM_DW-1:0] beat_data;
  logic [LANES-1:0]  beat_lanes;
  logic [MEM_AW-1:0] adr_nxt;

  // request captured at acceptance; bypassed while idle
  logic [WORD_W-1:0] word_q, word_now;
  logic [3:0]        sel_q, sel_now;
  logic [31:0]       dat_q, dat_now;
  logic              we_q, we_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sel_q  <= '0;
      dat_q  <= '0;
      we_q   <= 1'b0;
    end else if (accept) begin
      word_q <= wb_adr_i[ADDR_W-1:2];
      sel_q  <= wb_sel_i;
      dat_q  <= wb_dat_i;
      we_q   <= wb_we_i;
    end
  end

  assign word_now = busy ? word_q : wb_adr_i[ADDR_W-1:2];
  assign sel_now  = busy ? sel_q  : wb_sel_i;
  assign dat_now  = busy ? dat_q  : wb_dat_i;
  assign we_now   = busy ? we_q   : wb_we_i;

  sram_lane_steer #(.BEATS(BEATS)) u_steer (
    .we        (we_now),
    .sel       (sel_now),
    .wdata     (dat_now),
    .beat      (beat_nxt),
    .beat_data (beat_data),
    .beat_lanes(beat_lanes),
    .used      (used)
  );

  sram_seq #(
    .BEATS    (BEATS),
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .READ_CYC (READ_CYC)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .req     (wb_cyc_i && wb_stb_i),
    .we      (we_now),
    .used    (used),
    .busy    (busy),
    .accept  (accept),
    .load    (load),
    .cap     (cap),
    .beat_cur(beat_cur),
    .beat_nxt(beat_nxt),
    .ce_n    (mem_ce_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .dq_oe   (mem_dq_oe),
    .ack     (wb_ack_o)
  );

  if (BEATS == 1) begin : g_adr_word
    assign adr_nxt = word_now;
  end else begin : g_adr_beat
    assign adr_nxt = {word_now, beat_nxt};
  end

  // address, data and lanes change only when a beat is loaded
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_adr_o <= '0;
      mem_dq_o  <= '0;
      mem_be_n  <= '1;
    end else if (load) begin
      mem_adr_o <= adr_nxt;
      mem_dq_o  <= beat_data;
      mem_be_n  <= we_now ? ~beat_lanes : '0;
    end
  end

  sram_read_gather #(.BEATS(BEATS)) u_gather (
    .clk   (clk),
    .rst   (rst),
    .cap   (cap),
    .beat  (beat_cur),
    .din   (mem_dq_i),
    .word_o(wb_dat_o)
  );

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int MEM_AW    = 8,
  parameter int MEM_DW    = 32,
  parameter int PULSE_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic [MEM_AW-1:0] adr,
  input logic [MEM_DW-1:0] dq,
  input logic              dq_oe,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n
);

  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)        low_cnt <= '0;
    else if (!we_n) low_cnt <= low_cnt + 16'd1;
    else            low_cnt <= '0;
  end

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_oe_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (we_n && !dq_oe));

  assert_we_needs_drive_R6: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && dq_oe));

  assert_ack_released_R6: assert property (@(posedge clk) disable iff (rst)
    ack |-> (ce_n && !dq_oe));

  assert_we_addr_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> ($stable(adr) && $stable(dq)));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> ($stable(adr) && $stable(dq) && !ce_n));

  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (low_cnt == 16'(PULSE_CYC)));

endmodule

bind sram_bridge sram_bridge_chk #(
  .MEM_AW   (MEM_AW),
  .MEM_DW   (MEM_DW),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .ack  (wb_ack_o),
  .adr  (mem_adr_o),
  .dq   (mem_dq_o),
  .dq_oe(mem_dq_oe),
  .ce_n (mem_ce_n),
  .oe_n (mem_oe_n),
  .we_n (mem_we_n)
);

// File: tb/tb_sram_bridge.sv
`timescale 1ns/1ps
module tb_sram_model #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic [AW-1:0]   adr,
  input  logic [DW-1:0]   din,
  input  logic [DW/8-1:0] be_n,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic            we_n,
  output logic [DW-1:0]   dout
);
  logic [DW-1:0] mem [2**AW];

  initial begin
    for (int i = 0; i < 2**AW; i++)
      for (int l = 0; l < DW/8; l++)
        mem[i][l*8 +: 8] = 8'(((i * (DW/8) + l) * 7) + 3);
  end

  always @(posedge we_n) begin
    if (!ce_n)
      for (int l = 0; l < DW/8; l++)
        if (!be_n[l]) mem[adr][l*8 +: 8] <= din[l*8 +: 8];
  end

  assign dout = (!ce_n && !oe_n) ? mem[adr] : '1;
endmodule

module tb_sram_bridge;
  import sram_bridge_pkg::*;

  localparam int T_SET = 2, T_PUL = 3, T_HLD = 1, T_RD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  // unit 0: one 8-bit part, stretched stages
  logic        a_cyc = 0, a_stb = 0, a_we = 0;
  logic [9:0]  a_adr_i = '0;
  logic [3:0]  a_sel = '0;
  logic [31:0] a_wd = '0, a_rd;
  logic        a_ack, a_dq_oe, a_ce_n, a_oe_n, a_we_n;
  logic [9:0]  a_madr;
  logic [7:0]  a_dqi, a_dqo;
  logic [0:0]  a_be_n;

  // unit 1: one 32-bit part, default stages
  logic        b_cyc = 0, b_stb = 0, b_we = 0;
  logic [9:0]  b_adr_i = '0;
  logic [3:0]  b_sel = '0;
  logic [31:0] b_wd = '0, b_rd;
  logic        b_ack, b_dq_oe, b_ce_n, b_oe_n, b_we_n;
  logic [7:0]  b_madr;
  logic [31:0] b_dqi, b_dqo;
  logic [3:0]  b_be_n;

  sram_bridge #(.ADDR_W(10), .LAYOUT(LAY_ONE8), .SETUP_CYC(T_SET),
                .PULSE_CYC(T_PUL), .HOLD_CYC(T_HLD), .READ_CYC(T_RD)) dut (
    .clk(clk), .rst(rst), .wb_cyc_i(a_cyc), .wb_stb_i(a_stb), .wb_we_i(a_we),
    .wb_adr_i(a_adr_i), .wb_sel_i(a_sel), .wb_dat_i(a_wd), .wb_dat_o(a_rd),
    .wb_ack_o(a_ack), .mem_adr_o(a_madr), .mem_dq_i(a_dqi), .mem_dq_o(a_dqo),
    .mem_dq_oe(a_dq_oe), .mem_ce_n(a_ce_n), .mem_oe_n(a_oe_n),
    .mem_we_n(a_we_n), .mem_be_n(a_be_n));

  tb_sram_model #(.AW(10), .DW(8)) m8 (
    .adr(a_madr), .din(a_dqo), .be_n(a_be_n), .ce_n(a_ce_n), .oe_n(a_oe_n),
    .we_n(a_we_n), .dout(a_dqi));

  sram_bridge #(.ADDR_W(10), .LAYOUT(LAY_ONE32)) dut32 (
    .clk(clk), .rst(rst), .wb_cyc_i(b_cyc), .wb_stb_i(b_stb), .wb_we_i(b_we),
    .wb_adr_i(b_adr_i), .wb_sel_i(b_sel), .wb_dat_i(b_wd), .wb_dat_o(b_rd),
    .wb_ack_o(b_ack), .mem_adr_o(b_madr), .mem_dq_i(b_dqi), .mem_dq_o(b_dqo),
    .mem_dq_oe(b_dq_oe), .mem_ce_n(b_ce_n), .mem_oe_n(b_oe_n),
    .mem_we_n(b_we_n), .mem_be_n(b_be_n));

  tb_sram_model #(.AW(8), .DW(32)) m32 (
    .adr(b_madr), .din(b_dqo), .be_n(b_be_n), .ce_n(b_ce_n), .oe_n(b_oe_n),
    .we_n(b_we_n), .dout(b_dqi));

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] ref_a [1024];
  logic [7:0] ref_b [1024];

  // port monitor on unit 0
  int a_low = 0, a_last_pulse = 0, a_pulses = 0, a_stab_viol = 0, a_dir_viol = 0;
  logic [9:0] a_prev_adr = '0;
  logic [7:0] a_prev_dq = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!a_we_n && (a_madr != a_prev_adr || a_dqo != a_prev_dq)) a_stab_viol++;
      if (!a_oe_n && a_dq_oe) a_dir_viol++;
      if (!a_we_n) a_low++;
      else begin
        if (a_low != 0) begin a_last_pulse = a_low; a_pulses++; end
        a_low = 0;
      end
      a_prev_adr = a_madr;
      a_prev_dq  = a_dqo;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input int unit, input bit we, input logic [9:0] adr,
                      input logic [3:0] sel, input logic [31:0] wd,
                      output logic [31:0] rd, output int lat, output bit one_cyc);
    @(negedge clk);
    if (unit == 0) begin a_cyc = 1; a_stb = 1; a_we = we; a_adr_i = adr; a_sel = sel; a_wd = wd; end
    else           begin b_cyc = 1; b_stb = 1; b_we = we; b_adr_i = adr; b_sel = sel; b_wd = wd; end
    lat = 0;
    rd  = '0;
    while (lat < 400) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if ((unit == 0) ? a_ack : b_ack) break;
    end
    rd = (unit == 0) ? a_rd : b_rd;
    if (unit == 0) begin a_cyc = 0; a_stb = 0; end
    else           begin b_cyc = 0; b_stb = 0; end
    @(negedge clk);
    one_cyc = !((unit == 0) ? a_ack : b_ack);
  endtask

  function automatic int exp_lat(input int unit, input bit we, input logic [3:0] sel);
    if (unit == 0) return we ? ($countones(sel) * (T_SET + T_PUL + T_HLD) + 1)
                             : (4 * (T_SET + T_RD) + 1);
    return we ? ((sel != 0) ? 4 : 1) : 3;
  endfunction

  // run one transfer on a unit, update the reference image, check results
  task automatic run(input int unit, input bit we, input logic [9:0] adr,
                     input logic [3:0] sel, input logic [31:0] wd, input string tag);
    logic [31:0] rd, exp;
    int lat;
    bit one;
    int base;
    base = int'(adr) & ~3;
    for (int l = 0; l < 4; l++)
      exp[l*8 +: 8] = (unit == 0) ? ref_a[base + l] : ref_b[base + l];
    xfer(unit, we, adr, sel, wd, rd, lat, one);
    chk(lat == exp_lat(unit, we, sel), we ? "R4/R5" : "R3/R5",
        {tag, " ack latency"}, lat, exp_lat(unit, we, sel));
    chk(one, "R5", {tag, " ack single cycle"}, {31'd0, !one}, 32'd0);
    if (we) begin
      for (int l = 0; l < 4; l++)
        if (sel[l]) begin
          if (unit == 0) ref_a[base + l] = wd[l*8 +: 8];
          else           ref_b[base + l] = wd[l*8 +: 8];
        end
    end else begin
      chk(rd == exp, "R1/R2/R5", {tag, " read word"}, rd, exp);
    end
  endtask

  // {we, adr, sel, data}
  localparam logic [46:0] VEC [11] = '{
    {1'b1, 10'h040, 4'hF, 32'h11223344},
    {1'b0, 10'h040, 4'hF, 32'h0},
    {1'b1, 10'h044, 4'h3, 32'hAABBCCDD},
    {1'b0, 10'h044, 4'hF, 32'h0},
    {1'b1, 10'h3FC, 4'hF, 32'hDEADBEEF},
    {1'b0, 10'h3FC, 4'hF, 32'h0},
    {1'b1, 10'h040, 4'hA, 32'h55667788},
    {1'b0, 10'h040, 4'hF, 32'h0},
    {1'b0, 10'h000, 4'hF, 32'h0},
    {1'b1, 10'h042, 4'h4, 32'h00990000},
    {1'b0, 10'h043, 4'hF, 32'h0}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    for (int i = 0; i < 1024; i++) begin
      ref_a[i] = 8'((i * 7) + 3);
      ref_b[i] = 8'((i * 7) + 3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state of both units
    chk({a_ce_n, a_oe_n, a_we_n, a_be_n, a_dq_oe, a_ack} == 6'b111100, "R10",
        "unit0 idle pins", {26'd0, a_ce_n, a_oe_n, a_we_n, a_be_n, a_dq_oe, a_ack}, 32'h3C);
    chk({b_ce_n, b_oe_n, b_we_n, b_be_n, b_dq_oe, b_ack} == 9'b111111100, "R10",
        "unit1 idle pins", {23'd0, b_ce_n, b_oe_n, b_we_n, b_be_n, b_dq_oe, b_ack}, 32'h1FC);

    for (int v = 0; v < 11; v++)
      run(0, VEC[v][46], VEC[v][45:36], VEC[v][35:32], VEC[v][31:0], $sformatf("vec%0d", v));

    // R4: stretched write pulse length
    chk(a_last_pulse == T_PUL, "R4", "write pulse cycles", a_last_pulse, T_PUL);

    // R2: little-endian beat placement in the 8-bit model
    run(0, 1'b1, 10'h100, 4'hF, 32'h0A0B0C0D, "le write");
    chk({m8.mem[10'h103], m8.mem[10'h102], m8.mem[10'h101], m8.mem[10'h100]} == 32'h0A0B0C0D,
        "R2", "beat k at address base+k",
        {m8.mem[10'h103], m8.mem[10'h102], m8.mem[10'h101], m8.mem[10'h100]}, 32'h0A0B0C0D);

    // R8: all-clear selects: no pulse, immediate ack, memory untouched
    p0 = a_pulses;
    run(0, 1'b1, 10'h080, 4'h0, 32'hFFFFFFFF, "r8_empty write");
    chk(a_pulses == p0, "R8", "pulses on empty write", a_pulses - p0, 0);
    run(0, 1'b0, 10'h080, 4'hF, 32'h0, "r8_empty readback");

    // R8/R7: a single lane write performs one beat only
    p0 = a_pulses;
    run(0, 1'b1, 10'h084, 4'h4, 32'h00770000, "r8_single lane");
    chk(a_pulses == p0 + 1, "R8", "pulses on one-lane write", a_pulses - p0, 1);
    run(0, 1'b0, 10'h084, 4'hF, 32'h0, "r7_lane readback");

    // R1: 32-bit unit does one beat per word, byte lanes honoured
    run(1, 1'b1, 10'h010, 4'hF, 32'hCAFEF00D, "u32 write");
    chk(m32.mem[8'h04] == 32'hCAFEF00D, "R1", "32-bit word location", m32.mem[8'h04], 32'hCAFEF00D);
    run(1, 1'b1, 10'h010, 4'h6, 32'h12345678, "r7_u32 partial");
    run(1, 1'b0, 10'h010, 4'hF, 32'h0, "u32 read");
    run(1, 1'b0, 10'h3F0, 4'hF, 32'h0, "u32 init read");

    // R6, R9: port monitors over the whole run
    chk(a_dir_viol == 0, "R6", "output enable with driven data", a_dir_viol, 0);
    chk(a_stab_viol == 0, "R9", "address or data moved under write enable", a_stab_viol, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule